// File: doc/BRIEF.md
# DRAM Read Strobe Sequencer

This block produces the row strobe, column strobe and output-enable strobe for one DRAM memory area. A single request carries a read/write flag and an address already split into row and column parts. The block walks a fixed sequence. First the row strobe goes low with the row address on the shared address pins. Then the column strobe goes low with the column address for a programmable number of cycles. Both strobes then rise together. The row precharge interval follows, for its own programmable count, and after it the block reports ready again.

Two device kinds are supported, chosen per access by a type-select bit that is captured when the request is accepted. For fast-page-mode devices the output-enable pin stays inactive, because the device is assumed to have its own enable tied active. Read data is then captured on the rising clock edge where the column strobe ends. For extended-data-out devices the output enable is driven low on reads only. It stays low for half a clock past the end of the column strobe, and read data is captured on the falling edge where the output enable returns high. A register clocked on the falling edge provides that half-cycle extension.

A mode bit lengthens both programmed counts by one cycle. A captured read word is presented with a one-cycle valid pulse.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset, ras_n, cas_n and oe_n are high, ready is high and rd_valid is low.
- R2: A request is accepted only on a rising edge where req_valid and ready are both high. ready stays low until the access ends, and req_valid is ignored while ready is low.
- R3: On acceptance ras_n falls with the row on dram_addr. One clock later cas_n falls with the zero-extended column on dram_addr. cas_n is never low while ras_n is high, and both strobes rise on the same edge.
- R4: The effective count is N+A, where N is the programmed count (a value of 0 is treated as 1) and A is cfg_alt. This applies to both the access count and the precharge count. cas_n stays low for the effective access count in clock cycles.
- R5: ready rises the effective precharge count of clock cycles after ras_n rises.
- R6: cfg_fpm, cfg_cas_acc, cfg_ras_pre and cfg_alt are captured at acceptance. cfg_fpm=1 selects fast-page-mode and cfg_fpm=0 selects extended-data-out. Changes after acceptance do not affect the running access.
- R7: In fast-page-mode, oe_n stays high for the whole access.
- R8: In extended-data-out mode, oe_n stays high during writes.
- R9: In extended-data-out mode on a read, oe_n falls on the same edge as cas_n and rises on the falling clock edge half a cycle after cas_n rises.
- R10: On a fast-page-mode read, rd_data holds the dq_in value that was present just before the rising edge where cas_n rises. rd_valid is high in the cycle that starts at that edge.
- R11: On an extended-data-out read, rd_data holds the dq_in value that was present just before the falling edge where oe_n rises. rd_valid is high in the clock cycle that starts at the next rising edge.
- R12: Every read produces exactly one single-cycle rd_valid pulse, and a write produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state machine uses the rising edge, the output-enable extension and the extended-data-out capture use the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cfg_fpm | input | 1 | Device kind: 1 fast-page-mode, 0 extended-data-out |
| cfg_ras_pre | input | CNT_W | Programmed precharge count |
| cfg_cas_acc | input | CNT_W | Programmed column access count |
| cfg_alt | input | 1 | Adds one cycle to both counts |
| dq_in | input | DATA_W | Data pins from the device |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| rd_data | output | DATA_W | Captured read word |
| ready | output | 1 | Idle and able to accept a request |

## Verification
A corrupted state register or cycle timer shows up at the strobe pins within one clock. The ras_n-to-cas_n spacing, the cas_n width or the time from ras_n rising to ready rising is then off by whole cycles. A wrong captured device kind shows within half a clock of cas_n falling, when oe_n either moves when it should not or fails to move. A sample register clocked on the wrong edge changes which dq_in word reaches rd_data. The bench therefore drives dq_in with a different value at every clock edge, so a capture that is off by half a cycle is visible in the data.

// File: rtl/dstr_pkg.sv
`timescale 1ns / 1ps
package dstr_pkg;

   // State bits: [2] row strobe active, [1] column strobe active, [0] precharge.
   // Each strobe comes straight from one flop.
   typedef enum logic [2:0] {
      ST_IDLE = 3'b000,
      ST_ROW  = 3'b100,
      ST_COL  = 3'b110,
      ST_PRE  = 3'b001
   } seq_state_e;

   localparam int STATE_RAS_BIT = 2;
   localparam int STATE_CAS_BIT = 1;

endpackage

// File: rtl/dstr_cycle_timer.sv
`timescale 1ns / 1ps
module dstr_cycle_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          last
);

   logic [TW-1:0] cnt_q;

   if (TW < 2) begin : g_bad_tw
      $error("dstr_cycle_timer: TW must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - TW'(1);
      end
   end

   assign last = (cnt_q == TW'(1));

endmodule

// File: rtl/dstr_addr_mux.sv
`timescale 1ns / 1ps
module dstr_addr_mux #(
   parameter  int ROW_W  = 11,
   parameter  int COL_W  = 10,
   localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   input  logic              sel_col,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] row_ext;
   logic [ADDR_W-1:0] col_ext;

   if (ROW_W < ADDR_W) begin : g_row_pad
      assign row_ext = {{(ADDR_W-ROW_W){1'b0}}, row};
   end else begin : g_row_full
      assign row_ext = row;
   end

   if (COL_W < ADDR_W) begin : g_col_pad
      assign col_ext = {{(ADDR_W-COL_W){1'b0}}, col};
   end else begin : g_col_full
      assign col_ext = col;
   end

   assign addr = sel_col ? col_ext : row_ext;

endmodule

// File: rtl/dstr_oe_shaper.sv
`timescale 1ns / 1ps
module dstr_oe_shaper (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_req,
   output logic oe_hold,
   output logic oe_n
);

   // The falling-edge copy of the request keeps the enable low for half a
   // clock after the rising-edge request drops.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_hold <= 1'b0;
      end else begin
         oe_hold <= oe_req;
      end
   end

   assign oe_n = ~(oe_req | oe_hold);

endmodule

// File: rtl/dstr_read_capture.sv
`timescale 1ns / 1ps
module dstr_read_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fpm_cap,
   input  logic              oe_req,
   input  logic              oe_hold,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] edo_word_q;
   logic              edo_flag_q;

   if (DATA_W < 1) begin : g_bad_dw
      $error("dstr_read_capture: DATA_W must be positive");
   end

   // Falling edge where the held enable ends: capture the word.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edo_word_q <= '0;
         edo_flag_q <= 1'b0;
      end else if (oe_hold && !oe_req) begin
         edo_word_q <= dq_in;
         edo_flag_q <= 1'b1;
      end else begin
         edo_flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else if (fpm_cap) begin
         rd_data  <= dq_in;
         rd_valid <= 1'b1;
      end else if (edo_flag_q) begin
         rd_data  <= edo_word_q;
         rd_valid <= 1'b1;
      end else begin
         rd_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/dram_strobe_seq.sv
`timescale 1ns / 1ps
module dram_strobe_seq
   import dstr_pkg::*;
#(
   parameter  int ROW_W  = 11,
   parameter  int COL_W  = 10,
   parameter  int CNT_W  = 3,
   parameter  int DATA_W = 16,
   localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              cfg_fpm,
   input  logic [CNT_W-1:0]  cfg_ras_pre,
   input  logic [CNT_W-1:0]  cfg_cas_acc,
   input  logic              cfg_alt,
   input  logic [DATA_W-1:0] dq_in,
   output logic              ras_n,
   output logic              cas_n,
   output logic              oe_n,
   output logic [ADDR_W-1:0] dram_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              ready
);

   localparam int TW = CNT_W + 1;

   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("dram_strobe_seq: CNT_W out of range 1..8");
   end
   if (ROW_W < 1 || COL_W < 1) begin : g_bad_addr
      $error("dram_strobe_seq: address widths must be positive");
   end

   function automatic logic [TW-1:0] eff_count(input logic [CNT_W-1:0] c,
                                                input logic alt);
      logic [TW-1:0] base;
      base = (c == '0) ? TW'(1) : TW'(c);
      return base + TW'(alt);
   endfunction

   seq_state_e        state_q;
   logic              wr_q;
   logic              fpm_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [TW-1:0]     cas_eff_q;
   logic [TW-1:0]     pre_eff_q;

   logic              t_load;
   logic [TW-1:0]     t_val;
   logic              t_last;
   logic              oe_req;
   logic              oe_hold;
   logic              fpm_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         wr_q      <= 1'b0;
         fpm_q     <= 1'b1;
         row_q     <= '0;
         col_q     <= '0;
         cas_eff_q <= TW'(1);
         pre_eff_q <= TW'(1);
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q   <= ST_ROW;
                  wr_q      <= req_write;
                  fpm_q     <= cfg_fpm;
                  row_q     <= req_row;
                  col_q     <= req_col;
                  cas_eff_q <= eff_count(cfg_cas_acc, cfg_alt);
                  pre_eff_q <= eff_count(cfg_ras_pre, cfg_alt);
               end
            end
            ST_ROW:  state_q <= ST_COL;
            ST_COL:  if (t_last) state_q <= ST_PRE;
            ST_PRE:  if (t_last) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign t_load = (state_q == ST_ROW) || ((state_q == ST_COL) && t_last);
   assign t_val  = (state_q == ST_ROW) ? cas_eff_q : pre_eff_q;

   dstr_cycle_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .last     (t_last)
   );

   dstr_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
      .row     (row_q),
      .col     (col_q),
      .sel_col (state_q == ST_COL),
      .addr    (dram_addr)
   );

   assign oe_req  = (state_q == ST_COL) && !fpm_q && !wr_q;
   assign fpm_cap = (state_q == ST_COL) && t_last && fpm_q && !wr_q;

   dstr_oe_shaper u_oe (
      .clk     (clk),
      .rst_n   (rst_n),
      .oe_req  (oe_req),
      .oe_hold (oe_hold),
      .oe_n    (oe_n)
   );

   dstr_read_capture #(.DATA_W(DATA_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .fpm_cap  (fpm_cap),
      .oe_req   (oe_req),
      .oe_hold  (oe_hold),
      .dq_in    (dq_in),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assign ras_n = ~state_q[STATE_RAS_BIT];
   assign cas_n = ~state_q[STATE_CAS_BIT];
   assign ready = (state_q == ST_IDLE);

endmodule

// File: rtl/dstr_seq_checker.sv
`timescale 1ns / 1ps
module dstr_seq_checker (
   input logic clk,
   input logic rst_n,
   input logic ras_n,
   input logic cas_n,
   input logic oe_n,
   input logic ready,
   input logic rd_valid,
   input logic fpm_q,
   input logic wr_q
);

   assert_idle_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (ras_n && cas_n));

   assert_cas_within_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   assert_fpm_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fpm_q |-> oe_n);

   assert_edo_write_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fpm_q && wr_q) |-> oe_n);

   assert_edo_oe_with_cas_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && !fpm_q && !wr_q) |-> !oe_n);

   assert_edo_oe_extends_R9: assert property (@(negedge clk) disable iff (!rst_n)
      ($rose(cas_n) && !fpm_q && !wr_q) |-> !oe_n);

   assert_edo_oe_ends_R9: assert property (@(negedge clk) disable iff (!rst_n)
      ($rose(cas_n) && !fpm_q && !wr_q) |=> oe_n);

   assert_valid_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

bind dram_strobe_seq dstr_seq_checker u_seq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .oe_n     (oe_n),
   .ready    (ready),
   .rd_valid (rd_valid),
   .fpm_q    (fpm_q),
   .wr_q     (wr_q)
);

// File: tb/test_dram_strobe_seq.sv
`timescale 1ns / 1ps
module test_dram_strobe_seq;

   localparam int ROW_W  = 11;
   localparam int COL_W  = 10;
   localparam int CNT_W  = 3;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 11;

   typedef struct {
      bit      wr;
      bit      fpm;
      int      row;
      int      col;
      int      ecas;
      int      epre;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic              cfg_fpm = 1'b1;
   logic [CNT_W-1:0]  cfg_ras_pre = '0;
   logic [CNT_W-1:0]  cfg_cas_acc = '0;
   logic              cfg_alt = 1'b0;
   logic [DATA_W-1:0] dq_in = '0;
   logic              ras_n, cas_n, oe_n, rd_valid, ready;
   logic [ADDR_W-1:0] dram_addr;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int ec = 0;
   exp_t sb[$];

   int ras_f, ras_r, cas_f, cas_r, oe_f, oe_r, oe_falls, rv_cnt, rv_edge, rv_data;
   int row_seen, col_seen;
   bit p_ras = 1, p_cas = 1, p_oe = 1, p_rdy = 1;

   dram_strobe_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W), .DATA_W(DATA_W))
   i_dram_strobe_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_row(req_row), .req_col(req_col), .cfg_fpm(cfg_fpm),
      .cfg_ras_pre(cfg_ras_pre), .cfg_cas_acc(cfg_cas_acc), .cfg_alt(cfg_alt),
      .dq_in(dq_in), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
      .dram_addr(dram_addr), .rd_valid(rd_valid), .rd_data(rd_data), .ready(ready)
   );

   always #2.5 clk = ~clk;

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at edge %0d", tag, act, exp, ec);
      end
   endtask

   task automatic finish_access();
      exp_t e;
      if (sb.size() == 0) begin
         check("R2 unexpected access (queue empty)", 1, 0);
         return;
      end
      e = sb.pop_front();
      check("R3 row on dram_addr at ras_n fall", row_seen, e.row);
      check("R3 column on dram_addr at cas_n fall", col_seen, e.col);
      check("R3 ras_n to cas_n spacing (half-cycles)", cas_f - ras_f, 2);
      check("R3 ras_n and cas_n rise together", ras_r, cas_r);
      check("R4 cas_n low width (half-cycles)", cas_r - cas_f, 2 * e.ecas);
      check("R5 precharge before ready (half-cycles)", ec - cas_r, 2 * e.epre);
      if (e.fpm) begin
         check("R7 R6 fast-page oe_n falls", oe_falls, 0);
      end else if (e.wr) begin
         check("R8 R6 edo write oe_n falls", oe_falls, 0);
      end else begin
         check("R9 R6 edo read oe_n falls", oe_falls, 1);
         check("R9 oe_n fall edge equals cas_n fall", oe_f, cas_f);
         check("R9 oe_n rise edge", oe_r, cas_r + 1);
      end
      if (e.wr) begin
         check("R12 rd_valid pulses on write", rv_cnt, 0);
      end else begin
         check("R12 rd_valid pulses on read", rv_cnt, 1);
         if (e.fpm) begin
            check("R10 rd_valid edge", rv_edge, cas_r);
            check("R10 fast-page sampled word", rv_data, (cas_r - 1) & 16'hFFFF);
         end else begin
            check("R11 rd_valid edge", rv_edge, cas_r + 2);
            check("R11 edo sampled word", rv_data, cas_r & 16'hFFFF);
         end
      end
   endtask

   task automatic mon_step();
      bit pos;
      pos = clk;
      if (p_rdy && !ready) begin
         ras_f = -1; ras_r = -1; cas_f = -1; cas_r = -1; oe_f = -1; oe_r = -1;
         oe_falls = 0; rv_cnt = 0; rv_edge = -1; rv_data = -1;
      end
      if (p_ras && !ras_n) begin ras_f = ec; row_seen = int'(dram_addr); end
      if (!p_ras && ras_n) ras_r = ec;
      if (p_cas && !cas_n) begin cas_f = ec; col_seen = int'(dram_addr); end
      if (!p_cas && cas_n) cas_r = ec;
      if (p_oe && !oe_n) begin oe_f = ec; oe_falls++; end
      if (!p_oe && oe_n) oe_r = ec;
      if (pos && rd_valid) begin rv_cnt++; rv_edge = ec; rv_data = int'(rd_data); end
      if (!p_rdy && ready) finish_access();
      p_ras = ras_n; p_cas = cas_n; p_oe = oe_n; p_rdy = ready;
   endtask

   // Every edge gets a fresh dq_in tag so the capture edge is visible in the data.
   initial begin
      forever begin
         @(clk);
         ec++;
         #1 dq_in = ec[DATA_W-1:0];
         #1 mon_step();
      end
   end

   task automatic wait_ready();
      do begin
         @(posedge clk);
         #1;
      end while (!ready);
   endtask

   task automatic do_access(bit wr, bit fpm, int row, int col, int cas, int pre, bit alt);
      exp_t e;
      wait_ready();
      req_valid = 1'b1; req_write = wr; cfg_fpm = fpm;
      req_row = row[ROW_W-1:0]; req_col = col[COL_W-1:0];
      cfg_cas_acc = cas[CNT_W-1:0]; cfg_ras_pre = pre[CNT_W-1:0]; cfg_alt = alt;
      e.wr = wr; e.fpm = fpm; e.row = row & 11'h7FF; e.col = col & 10'h3FF;
      e.ecas = ((cas == 0) ? 1 : cas) + int'(alt);
      e.epre = ((pre == 0) ? 1 : pre) + int'(alt);
      sb.push_back(e);
      @(posedge clk); #1;
      req_valid = 1'b0;
      // R6: configuration changes after acceptance must not matter
      cfg_fpm = ~fpm; cfg_cas_acc = 3'd5; cfg_ras_pre = 3'd6; cfg_alt = ~alt;
      // R2: a stray request while busy must be ignored
      @(posedge clk); #1;
      req_valid = 1'b1; req_row = 11'h555; req_write = ~wr;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   initial begin
      #400000;
      if (!finished) begin
         errors++;
         $display("FAIL R2 watchdog: ready actual=%0b expected=1", ready);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 ras_n in reset", int'(ras_n), 1);
      check("R1 cas_n in reset", int'(cas_n), 1);
      check("R1 oe_n in reset", int'(oe_n), 1);
      check("R1 ready in reset", int'(ready), 1);
      check("R1 rd_valid in reset", int'(rd_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check("R1 ready after reset", int'(ready), 1);
      check("R1 ras_n after reset", int'(ras_n), 1);

      do_access(0, 1, 11'h123, 10'h045, 2, 2, 0);
      do_access(0, 0, 11'h7FF, 10'h3FF, 3, 1, 0);
      do_access(1, 0, 11'h0A5, 10'h15A, 1, 2, 0);
      do_access(1, 1, 11'h400, 10'h201, 2, 3, 1);
      do_access(0, 0, 11'h001, 10'h002, 0, 0, 0);
      do_access(0, 0, 11'h2AA, 10'h155, 7, 7, 1);
      do_access(0, 1, 11'h000, 10'h000, 0, 0, 1);
      do_access(0, 1, 11'h3C3, 10'h0F0, 7, 1, 0);
      do_access(0, 0, 11'h111, 10'h222, 1, 1, 1);
      do_access(1, 0, 11'h666, 10'h333, 4, 1, 0);
      do_access(0, 0, 11'h050, 10'h0A0, 1, 1, 0);

      wait_ready();
      repeat (4) @(posedge clk);
      #1;
      check("R2 pending accesses at end", sb.size(), 0);
      check("R1 strobes idle at end", int'(ras_n & cas_n & oe_n), 1);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule